// File: doc/BRIEF.md
# Per-Core Interrupt Steering and Pending Aggregator

This block collects the interrupt sources of a four-core cluster and steers each one to a core's normal interrupt (IRQ) or fast interrupt (FIQ) line. Every core has four timer lines, four mailbox lines and one performance-monitor line. One shared graphics-side interrupt is placed on a core by a core-select field, not by per-core enables. For each core it builds an IRQ pending word and a FIQ pending word. The core's output lines are the OR of those words.

Software reaches the block through a single-cycle 32-bit register port. A write takes effect on the clock edge where it is sampled. Read data is combinational from the address. Each timer and mailbox source has its own IRQ enable and FIQ enable. When both are set, the FIQ enable wins, so a source never shows up in both pending words. The performance-monitor enables are changed through separate set and clear addresses, so no read-modify-write is needed.

Top module: `core_irq_router`

## Requirements
- R1: After reset every control register reads zero, and no timer, mailbox or performance-monitor line can raise a pending bit or an output.
- R2: The timer control register of core c is at 0x40+4c. Bit t is the IRQ enable of timer t. A high timer line t that has its IRQ enable set and its FIQ enable clear sets bit t of that core's IRQ pending word.
- R3: Timer FIQ enables are bits [7:4] of the same register, with bit t+4 for timer t. A set FIQ enable routes the timer to FIQ pending bit t and keeps it out of the IRQ pending word, whatever the IRQ enable holds.
- R4: The mailbox control register of core c is at 0x50+4c, with IRQ enables in [3:0] and FIQ enables in [7:4]. FIQ overrides IRQ. Mailbox m appears at pending bit 4+m.
- R5: The shared-source routing register is at 0x0C. Bits [1:0] select the IRQ core, bits [3:2] select the FIQ core, and bit 4 chooses FIQ (1) or IRQ (0). The shared line then appears at pending bit 8 of exactly that one core and word.
- R6: Writing ones at 0x10 sets bits of the 4-bit performance-monitor enable mask, and writing ones at 0x14 clears them. A read of either address returns the mask. An enabled core's monitor line sets IRQ pending bit 9.
- R7: Core c's IRQ pending word reads at 0x60+4c and its FIQ pending word at 0x70+4c. Bits 31:10 read zero.
- R8: Writes to pending addresses, to unmapped addresses or to addresses with nonzero bits [1:0] change no state. Unmapped addresses read zero.
- R9: A core's irq_out is high exactly when its IRQ pending word is nonzero, and its fiq_out is high exactly when its FIQ pending word is nonzero.
- R10: Control registers hold only their defined bits: the timer and mailbox registers keep bits [7:0] and the routing register keeps bits [4:0]. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tmr_line | input | 16 | Timer lines, bit 4c+t is timer t of core c |
| mbx_line | input | 16 | Mailbox lines, bit 4c+m is mailbox m of core c |
| gpu_line | input | 1 | Shared interrupt line steered by the routing register |
| pmu_line | input | 4 | Performance-monitor line per core |
| irq_out | output | 4 | Normal interrupt request per core |
| fiq_out | output | 4 | Fast interrupt request per core |

## Verification
The assertions check on every cycle that no core has the same bit pending in both words. They also check that the upper pending bits read zero, that the outputs stay low while every source line is low, and that the performance-monitor mask changes only through its set and clear addresses. Only the bench's scenarios can show that a given enable pattern routes a given source to the right core and word. The bench also covers core-select decoding of the shared line, ignored writes and register read-back. It sweeps many pseudo-random configurations and line patterns and compares them with a model computed from the requirements.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
  localparam int SRC_PER_CORE = 4;
  localparam int PEND_W       = 10;
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = 32;
  localparam int CTL_W        = 2 * SRC_PER_CORE;

  // pending word bit positions
  localparam int BIT_TMR = 0;
  localparam int BIT_MBX = 4;
  localparam int BIT_GPU = 8;
  localparam int BIT_PMU = 9;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_GPU     = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PMU_SET = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PMU_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_TMR     = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_MBX     = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_IRQP    = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_FIQP    = 8'h70;

  typedef struct packed {
    logic [SRC_PER_CORE-1:0] fiq_en;
    logic [SRC_PER_CORE-1:0] irq_en;
  } src_ctl_t;

  typedef struct packed {
    logic       fiq_mode;
    logic [1:0] fiq_core;
    logic [1:0] irq_core;
  } gpu_route_t;

  localparam int GPU_W = $bits(gpu_route_t);
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output src_ctl_t [NCORES-1:0]    tmr_ctl,
  output src_ctl_t [NCORES-1:0]    mbx_ctl,
  output gpu_route_t               gpu_rt,
  output logic [NCORES-1:0]        pmu_en
);
  logic                  aligned_wr;
  logic [NCORES-1:0]     tmr_we, mbx_we;
  logic                  gpu_we, pmu_we;
  logic [NCORES-1:0]     pmu_nx;
  src_ctl_t [NCORES-1:0] tmr_q, mbx_q;
  gpu_route_t            gpu_q;
  logic [NCORES-1:0]     pmu_q;

  // next-state and enable decode
  always_comb begin
    aligned_wr = wr_en && (addr[1:0] == 2'b00);
    gpu_we     = aligned_wr && (addr == OFS_GPU);
    pmu_we     = aligned_wr && ((addr == OFS_PMU_SET) || (addr == OFS_PMU_CLR));
    pmu_nx     = pmu_q;
    if (addr == OFS_PMU_SET) pmu_nx = pmu_q | wdata[NCORES-1:0];
    if (addr == OFS_PMU_CLR) pmu_nx = pmu_q & ~wdata[NCORES-1:0];
    for (int c = 0; c < NCORES; c++) begin
      tmr_we[c] = aligned_wr && (addr == OFS_TMR + ADDR_W'(4 * c));
      mbx_we[c] = aligned_wr && (addr == OFS_MBX + ADDR_W'(4 * c));
    end
  end

  // register processes
  for (genvar c = 0; c < NCORES; c++) begin : g_core_regs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tmr_q[c] <= '0;
      else if (tmr_we[c]) tmr_q[c] <= src_ctl_t'(wdata[CTL_W-1:0]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mbx_q[c] <= '0;
      else if (mbx_we[c]) mbx_q[c] <= src_ctl_t'(wdata[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gpu_q <= '0;
    else if (gpu_we) gpu_q <= gpu_route_t'(wdata[GPU_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pmu_q <= '0;
    else if (pmu_we) pmu_q <= pmu_nx;
  end

  assign tmr_ctl = tmr_q;
  assign mbx_ctl = mbx_q;
  assign gpu_rt  = gpu_q;
  assign pmu_en  = pmu_q;
endmodule

// File: rtl/irq_core_steer.sv
`timescale 1ns/1ps
module irq_core_steer
  import irq_router_pkg::*;
(
  input  logic [SRC_PER_CORE-1:0] tmr_line,
  input  logic [SRC_PER_CORE-1:0] mbx_line,
  input  src_ctl_t                tmr_ctl,
  input  src_ctl_t                mbx_ctl,
  input  logic                    gpu_irq,
  input  logic                    gpu_fiq,
  input  logic                    pmu_irq,
  output logic [PEND_W-1:0]       irq_pend,
  output logic [PEND_W-1:0]       fiq_pend
);
  always_comb begin
    irq_pend = '0;
    fiq_pend = '0;
    // fast path takes precedence over normal path per source
    irq_pend[BIT_TMR +: SRC_PER_CORE] = tmr_line & tmr_ctl.irq_en & ~tmr_ctl.fiq_en;
    fiq_pend[BIT_TMR +: SRC_PER_CORE] = tmr_line & tmr_ctl.fiq_en;
    irq_pend[BIT_MBX +: SRC_PER_CORE] = mbx_line & mbx_ctl.irq_en & ~mbx_ctl.fiq_en;
    fiq_pend[BIT_MBX +: SRC_PER_CORE] = mbx_line & mbx_ctl.fiq_en;
    irq_pend[BIT_GPU] = gpu_irq;
    fiq_pend[BIT_GPU] = gpu_fiq;
    irq_pend[BIT_PMU] = pmu_irq;
  end
endmodule

// File: rtl/core_irq_router.sv
`timescale 1ns/1ps
module core_irq_router
  import irq_router_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr_en,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  output logic [DATA_W-1:0]              reg_rdata,
  input  logic [NCORES*SRC_PER_CORE-1:0] tmr_line,
  input  logic [NCORES*SRC_PER_CORE-1:0] mbx_line,
  input  logic                           gpu_line,
  input  logic [NCORES-1:0]              pmu_line,
  output logic [NCORES-1:0]              irq_out,
  output logic [NCORES-1:0]              fiq_out
);
  logic                             rst_sync_n;
  src_ctl_t [NCORES-1:0]            tmr_ctl, mbx_ctl;
  gpu_route_t                       gpu_rt;
  logic [NCORES-1:0]                pmu_en;
  logic [NCORES-1:0][PEND_W-1:0]    irq_pend, fiq_pend;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cfg_regs #(.NCORES(NCORES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .tmr_ctl (tmr_ctl),
    .mbx_ctl (mbx_ctl),
    .gpu_rt  (gpu_rt),
    .pmu_en  (pmu_en)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic gpu_to_irq, gpu_to_fiq;
    assign gpu_to_irq = gpu_line & ~gpu_rt.fiq_mode & (gpu_rt.irq_core == 2'(c));
    assign gpu_to_fiq = gpu_line &  gpu_rt.fiq_mode & (gpu_rt.fiq_core == 2'(c));

    irq_core_steer u_steer (
      .tmr_line (tmr_line[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .mbx_line (mbx_line[c*SRC_PER_CORE +: SRC_PER_CORE]),
      .tmr_ctl  (tmr_ctl[c]),
      .mbx_ctl  (mbx_ctl[c]),
      .gpu_irq  (gpu_to_irq),
      .gpu_fiq  (gpu_to_fiq),
      .pmu_irq  (pmu_line[c] & pmu_en[c]),
      .irq_pend (irq_pend[c]),
      .fiq_pend (fiq_pend[c])
    );

    assign irq_out[c] = |irq_pend[c];
    assign fiq_out[c] = |fiq_pend[c];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (reg_addr == OFS_GPU) reg_rdata = DATA_W'(gpu_rt);
      if ((reg_addr == OFS_PMU_SET) || (reg_addr == OFS_PMU_CLR)) reg_rdata = DATA_W'(pmu_en);
      for (int c = 0; c < NCORES; c++) begin
        if (reg_addr == OFS_TMR  + ADDR_W'(4 * c)) reg_rdata = DATA_W'(tmr_ctl[c]);
        if (reg_addr == OFS_MBX  + ADDR_W'(4 * c)) reg_rdata = DATA_W'(mbx_ctl[c]);
        if (reg_addr == OFS_IRQP + ADDR_W'(4 * c)) reg_rdata = DATA_W'(irq_pend[c]);
        if (reg_addr == OFS_FIQP + ADDR_W'(4 * c)) reg_rdata = DATA_W'(fiq_pend[c]);
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int NCORES = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr_en,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic [NCORES*SRC_PER_CORE-1:0] tmr_line,
  input logic [NCORES*SRC_PER_CORE-1:0] mbx_line,
  input logic                           gpu_line,
  input logic [NCORES-1:0]              pmu_line,
  input logic [NCORES-1:0]              irq_out,
  input logic [NCORES-1:0]              fiq_out,
  input logic [NCORES-1:0]              pmu_en,
  input logic [NCORES-1:0][PEND_W-1:0]  irq_pend,
  input logic [NCORES-1:0][PEND_W-1:0]  fiq_pend
);
  logic pend_rd, pmu_set_wr, pmu_clr_wr;
  assign pend_rd    = (reg_addr[7:5] == 3'b011) && (reg_addr[1:0] == 2'b00);
  assign pmu_set_wr = reg_wr_en && (reg_addr == OFS_PMU_SET);
  assign pmu_clr_wr = reg_wr_en && (reg_addr == OFS_PMU_CLR);

  for (genvar c = 0; c < NCORES; c++) begin : g_excl
    // R3
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend[c] & fiq_pend[c]) == '0);
  end

  // R7
  pend_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd |-> (reg_rdata[DATA_W-1:PEND_W] == '0));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gpu_line && tmr_line == '0 && mbx_line == '0 && pmu_line == '0)
      |-> (irq_out == '0 && fiq_out == '0));

  // R6
  pmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_set_wr |=> ((pmu_en & $past(reg_wdata[NCORES-1:0])) == $past(reg_wdata[NCORES-1:0])));

  // R6
  pmu_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmu_clr_wr |=> ((pmu_en & $past(reg_wdata[NCORES-1:0])) == '0));

  // R8
  pmu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pmu_set_wr || pmu_clr_wr) |=> $stable(pmu_en));
endmodule

bind core_irq_router irq_router_chk #(.NCORES(NCORES)) u_chk (.*);

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] tmr_line, mbx_line;
  logic        gpu_line;
  logic [3:0]  pmu_line;
  logic [3:0]  irq_out, fiq_out;

  always #5 clk = ~clk;

  core_irq_router #(.NCORES(NC)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0]  tc [NC];
  logic [7:0]  mc [NC];
  logic [4:0]  gr;
  logic [3:0]  pm;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_irq(int c);
    logic [31:0] w = '0;
    for (int t = 0; t < 4; t++) begin
      w[t]   = tmr_line[c*4+t] & tc[c][t] & ~tc[c][t+4];
      w[4+t] = mbx_line[c*4+t] & mc[c][t] & ~mc[c][t+4];
    end
    w[8] = gpu_line & ~gr[4] & (gr[1:0] == 2'(c));
    w[9] = pmu_line[c] & pm[c];
    return w;
  endfunction

  function automatic logic [31:0] exp_fiq(int c);
    logic [31:0] w = '0;
    for (int t = 0; t < 4; t++) begin
      w[t]   = tmr_line[c*4+t] & tc[c][t+4];
      w[4+t] = mbx_line[c*4+t] & mc[c][t+4];
    end
    w[8] = gpu_line & gr[4] & (gr[3:2] == 2'(c));
    return w;
  endfunction

  task automatic check_all();
    logic [31:0] d;
    for (int c = 0; c < NC; c++) begin
      rd(8'h60 + 8'(4*c), d); check("R2/R4/R5/R6 R7 irq pending", d, exp_irq(c));
      rd(8'h70 + 8'(4*c), d); check("R3/R4/R5 R7 fiq pending", d, exp_fiq(c));
      check("R9 irq_out", 32'(irq_out[c]), 32'(|exp_irq(c)));
      check("R9 fiq_out", 32'(fiq_out[c]), 32'(|exp_fiq(c)));
      rd(8'h40 + 8'(4*c), d); check("R10 timer ctl readback", d, 32'(tc[c]));
      rd(8'h50 + 8'(4*c), d); check("R10 mailbox ctl readback", d, 32'(mc[c]));
    end
    rd(8'h0C, d); check("R5 routing readback", d, 32'(gr));
    rd(8'h10, d); check("R6 mask via set addr", d, 32'(pm));
    rd(8'h14, d); check("R6 mask via clear addr", d, 32'(pm));
  endtask

  initial begin
    logic [31:0] d, r;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    tmr_line = '1; mbx_line = '1; gpu_line = 1'b0; pmu_line = '1;
    for (int c = 0; c < NC; c++) begin tc[c] = '0; mc[c] = '0; end
    gr = '0; pm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, all lines high but nothing pending
    check("R1 irq_out after reset", 32'(irq_out), 32'h0);
    check("R1 fiq_out after reset", 32'(fiq_out), 32'h0);
    check_all();

    // R2: core0 timer0 to IRQ
    tmr_line = 16'h0001; mbx_line = '0; pmu_line = '0;
    wr(8'h40, 32'h01); tc[0] = 8'h01;
    rd(8'h60, d); check("R2 timer irq pending", d, 32'h001);
    check("R2 irq_out core0", 32'(irq_out), 32'h1);
    // R3: FIQ override
    wr(8'h40, 32'h11); tc[0] = 8'h11;
    rd(8'h60, d); check("R3 irq word cleared", d, 32'h000);
    rd(8'h70, d); check("R3 fiq pending", d, 32'h001);
    check("R3 fiq_out core0", 32'(fiq_out), 32'h1);

    // R4: core2 mailbox3
    tmr_line = '0; mbx_line = 16'h0800;
    wr(8'h58, 32'h08); mc[2] = 8'h08;
    rd(8'h68, d); check("R4 mailbox irq pending", d, 32'h080);
    wr(8'h58, 32'h88); mc[2] = 8'h88;
    rd(8'h68, d); check("R4 mailbox irq cleared", d, 32'h000);
    rd(8'h78, d); check("R4 mailbox fiq pending", d, 32'h080);

    // R5: shared line steering
    mbx_line = '0; gpu_line = 1'b1;
    rd(8'h60, d); check("R5 default core0 irq", d, 32'h100);
    wr(8'h0C, 32'h02); gr = 5'h02;
    rd(8'h68, d); check("R5 irq core2", d, 32'h100);
    rd(8'h60, d); check("R5 not on core0", d, 32'h000);
    wr(8'h0C, 32'h1C); gr = 5'h1C;
    rd(8'h7C, d); check("R5 fiq core3", d, 32'h100);
    check("R5 irq_out all low", 32'(irq_out), 32'h0);
    check("R5 fiq_out core3 only", 32'(fiq_out), 32'h8);

    // R6: set / clear mask
    gpu_line = 1'b0; pmu_line = 4'hF;
    wr(8'h10, 32'h5); pm = 4'h5;
    rd(8'h14, d); check("R6 mask after set", d, 32'h5);
    rd(8'h60, d); check("R6 pmu pending core0", d, 32'h200);
    rd(8'h64, d); check("R6 pmu masked core1", d, 32'h000);
    wr(8'h14, 32'h1); pm = 4'h4;
    rd(8'h10, d); check("R6 mask after clear", d, 32'h4);
    check("R6 irq_out core2 only", 32'(irq_out), 32'h4);

    // R8: ignored writes
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h41, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h60, d); check("R8 pending write ignored", d, 32'h000);
    rd(8'h40, d); check("R8 misaligned write ignored", d, 32'h11);
    rd(8'h20, d); check("R8 unmapped reads zero", d, 32'h0);
    check("R8 irq_out unchanged", 32'(irq_out), 32'h4);
    check_all();

    // R10: only defined bits stored
    wr(8'h44, 32'hFFFF_FFFF); tc[1] = 8'hFF;
    rd(8'h44, d); check("R10 timer ctl width", d, 32'hFF);
    wr(8'h0C, 32'hFFFF_FFFF); gr = 5'h1F;
    rd(8'h0C, d); check("R10 routing width", d, 32'h1F);

    // sweep of configurations and line patterns
    for (int it = 0; it < 300; it++) begin
      for (int c = 0; c < NC; c++) begin
        r = rnd(); wr(8'h40 + 8'(4*c), r); tc[c] = r[7:0];
        r = rnd(); wr(8'h50 + 8'(4*c), r); mc[c] = r[7:0];
      end
      r = rnd(); wr(8'h0C, r); gr = r[4:0];
      r = rnd(); wr(8'h10, r); pm = pm | r[3:0];
      r = rnd(); wr(8'h14, r & 32'h5); pm = pm & ~(r[3:0] & 4'h5);
      r = rnd(); tmr_line = r[15:0]; mbx_line = r[31:16];
      r = rnd(); gpu_line = r[0]; pmu_line = r[7:4];
      #1;
      check_all();
    end

    tmr_line = '0; mbx_line = '0; gpu_line = 1'b0; pmu_line = '0;
    #1;
    check("R9 quiet lines no irq", 32'(irq_out), 32'h0);
    check("R9 quiet lines no fiq", 32'(fiq_out), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule